// File: doc/BRIEF.md
# Segmented Egress Framing Monitor

This block sits passively beside a wide streaming bus that carries packets in up to eight parallel segments per clock and offers no ready signal. The sender may present a beat in any cycle. The monitor has to judge every beat in the cycle it arrives, because it cannot stall the sender. It walks the enabled segments from index 0 upward and tracks whether a packet is open. That state carries from the top segment of one beat into segment 0 of the next. Each correctly closed packet is counted.

A static rate input selects 2, 4 or 8 active segments. The rate also sets how many packet starts and ends one beat may hold. The monitor reports six kinds of fault:

- three framing faults;
- two per-beat limit faults (too many starts, too many ends);
- one configuration fault (an enable set outside the active range).

Each fault sets a sticky flag. Any fault in a beat also produces a single-cycle pulse. All outputs are registered and show the effect of a beat one clock after it is sampled.

Only the framing sideband is examined. Payload words are not looked at.

Top module: `egress_frame_monitor`

## Requirements
- R1: A segment takes part only when `port_valid` and its `seg_en` bit are both high. In a cycle with `port_valid` low, nothing changes: not the count, not the open-packet state, not the flags, and no pulse.
- R2: The rate code sets the number of active segments. Code 0 gives 2 segments, code 1 gives 4, code 2 gives 8, and code 3 behaves like code 0. An enabled segment at or above the active count, in a valid cycle, sets flag bit 5. That segment is then left out of framing and of the limit counts.
- R3: Segments are judged in ascending index order. The open-packet state after the highest segment of one valid cycle is the state seen by segment 0 of the next valid cycle.
- R4: Idle segments (enable low) may appear anywhere, before a start or between packets. They never cause a flag.
- R5: A start while a packet is open sets flag bit 0. The old packet is dropped and the new start opens a packet.
- R6: An end while no packet is open sets flag bit 1.
- R7: A taking-part segment that has neither start nor end, while no packet is open, sets flag bit 2.
- R8: A segment with both start and end set is a complete one-segment packet.
- R9: `good_pkts` rises by one for every end that closes an open packet. It is registered, and it wraps modulo 2^CNT_W.
- R10: More starts in one valid cycle than the rate allows sets flag bit 3. The start limit is 1 at 2 and 4 segments, and 2 at 8 segments.
- R11: More ends in one valid cycle than the rate allows sets flag bit 4. The end limit is 1 at 2 segments, 2 at 4 segments, and 3 at 8 segments.
- R12: Flag bits stay set until reset. `err_pulse` is high for exactly the one cycle after each valid cycle that raised any flag condition.
- R13: A synchronous active-low `rst_n` clears the count, the flags, the pulse and the open-packet state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 2 | Rate code: 0 = 2 segments, 1 = 4, 2 = 8, 3 = as code 0 |
| port_valid | input | 1 | Beat present this cycle |
| seg_en | input | NSEG | Per-segment enable |
| seg_sop | input | NSEG | Per-segment packet start |
| seg_eop | input | NSEG | Per-segment packet end |
| good_pkts | output | CNT_W | Count of correctly closed packets |
| err_flags | output | 6 | Sticky faults: bit 0 = duplicate start, 1 = orphan end, 2 = data outside packet, 3 = start limit, 4 = end limit, 5 = enable out of range |
| err_pulse | output | 1 | One-cycle fault pulse |

## Verification
The hardest case to reach is a beat that sits exactly on a per-rate limit. At 8 segments that means two starts and three ends in one beat with no fault. Such a beat needs a packet already open from the previous beat, so that its first end closes that packet. Directed sequences build this state over two beats. They then push one start over the limit to confirm that the fault appears only then. Seeded random beats at each rate, with idle segments and stray enables mixed in, cover the carry of open-packet state across beats.

// File: rtl/egr_mon_pkg.sv
// Package: shared rate codes, fault bit positions and per-rate limits
// for the segmented egress framing monitor.
package egr_mon_pkg;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'd0,
        RATE_MID  = 2'd1,
        RATE_HIGH = 2'd2,
        RATE_RSVD = 2'd3
    } rate_e;

    localparam int ERR_W          = 6;
    localparam int ERR_DUP_SOP    = 0;
    localparam int ERR_ORPHAN_EOP = 1;
    localparam int ERR_NO_SOP     = 2;
    localparam int ERR_SOP_LIM    = 3;
    localparam int ERR_EOP_LIM    = 4;
    localparam int ERR_CFG        = 5;

    localparam int SOP_MAX_LOW  = 1;
    localparam int SOP_MAX_MID  = 1;
    localparam int SOP_MAX_HIGH = 2;
    localparam int EOP_MAX_LOW  = 1;
    localparam int EOP_MAX_MID  = 2;
    localparam int EOP_MAX_HIGH = 3;

endpackage

// File: rtl/seg_rate_decode.sv
// seg_rate_decode: turns the static rate code into a mask of active
// segments and the per-beat start/end limits.
// Assumes NSEG is divisible by 4 (low rate = NSEG/4, mid = NSEG/2).
module seg_rate_decode
    import egr_mon_pkg::*;
#(
    parameter int NSEG = 8,
    localparam int CW  = $clog2(NSEG + 1)
) (
    input  logic [1:0]      rate_sel,
    output logic [NSEG-1:0] active_mask,
    output logic [CW-1:0]   sop_max,
    output logic [CW-1:0]   eop_max
);

    logic [CW-1:0] n_active;

    // Pick the active segment count and the limits for the selected rate.
    always_comb begin
        case (rate_e'(rate_sel))
            RATE_MID: begin
                n_active = CW'(NSEG / 2);
                sop_max  = CW'(SOP_MAX_MID);
                eop_max  = CW'(EOP_MAX_MID);
            end
            RATE_HIGH: begin
                n_active = CW'(NSEG);
                sop_max  = CW'(SOP_MAX_HIGH);
                eop_max  = CW'(EOP_MAX_HIGH);
            end
            default: begin
                n_active = CW'(NSEG / 4);
                sop_max  = CW'(SOP_MAX_LOW);
                eop_max  = CW'(EOP_MAX_LOW);
            end
        endcase
    end

    // One mask bit per segment: active when below the active count.
    for (genvar gi = 0; gi < NSEG; gi++) begin : g_mask
        assign active_mask[gi] = (CW'(gi) < n_active);
    end

    // Segment 0 is active at every rate.
    always_comb begin
        assert_seg0_active_R2: assert (active_mask[0] == 1'b1);
    end

endmodule

// File: rtl/seg_limit_check.sv
// seg_limit_check: counts the starts and ends among the segments taking
// part in this beat and compares each count with its limit.
// Assumes qual already holds port_valid, enable and the active mask.
module seg_limit_check #(
    parameter int NSEG = 8,
    localparam int CW  = $clog2(NSEG + 1)
) (
    input  logic [NSEG-1:0] qual,
    input  logic [NSEG-1:0] seg_sop,
    input  logic [NSEG-1:0] seg_eop,
    input  logic [CW-1:0]   sop_max,
    input  logic [CW-1:0]   eop_max,
    output logic            sop_over,
    output logic            eop_over
);

    logic [CW-1:0] sop_cnt;
    logic [CW-1:0] eop_cnt;

    // Add up the qualified start and end flags.
    always_comb begin
        sop_cnt = '0;
        eop_cnt = '0;
        for (int i = 0; i < NSEG; i++) begin
            sop_cnt = sop_cnt + CW'(qual[i] & seg_sop[i]);
            eop_cnt = eop_cnt + CW'(qual[i] & seg_eop[i]);
        end
    end

    // Compare each count with its limit.
    assign sop_over = (sop_cnt > sop_max);
    assign eop_over = (eop_cnt > eop_max);

    // A beat with no qualified start or end can never break a limit.
    always_comb begin
        if ((qual & seg_sop) == '0)
            assert_no_sop_no_over_R10: assert (!sop_over);
        if ((qual & seg_eop) == '0)
            assert_no_eop_no_over_R11: assert (!eop_over);
    end

endmodule

// File: rtl/seg_frame_walk.sv
// seg_frame_walk: walks the qualified segments in ascending order from
// the incoming open-packet state. It returns the outgoing state, the
// number of correctly closed packets and the three framing faults.
// Purely combinational; the caller holds the state register.
module seg_frame_walk #(
    parameter int NSEG = 8,
    localparam int CW  = $clog2(NSEG + 1)
) (
    input  logic            in_pkt_i,
    input  logic [NSEG-1:0] qual,
    input  logic [NSEG-1:0] seg_sop,
    input  logic [NSEG-1:0] seg_eop,
    output logic            in_pkt_o,
    output logic [CW-1:0]   good_cnt,
    output logic            dup_sop,
    output logic            orphan_eop,
    output logic            no_sop
);

    // Sequential framing walk across the segments of one beat.
    always_comb begin
        logic st;
        st         = in_pkt_i;
        good_cnt   = '0;
        dup_sop    = 1'b0;
        orphan_eop = 1'b0;
        no_sop     = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            if (qual[i]) begin
                if (seg_sop[i]) begin
                    if (st) dup_sop = 1'b1;
                    st = 1'b1;
                    if (seg_eop[i]) begin
                        good_cnt = good_cnt + CW'(1);
                        st       = 1'b0;
                    end
                end else if (seg_eop[i]) begin
                    if (st) begin
                        good_cnt = good_cnt + CW'(1);
                        st       = 1'b0;
                    end else begin
                        orphan_eop = 1'b1;
                    end
                end else if (!st) begin
                    no_sop = 1'b1;
                end
            end
        end
        in_pkt_o = st;
    end

    // Closed packets never outnumber the qualified ends.
    always_comb begin
        assert_good_le_eops_R9: assert (good_cnt <= CW'($countones(qual & seg_eop)));
    end

endmodule

// File: rtl/egress_frame_monitor.sv
// egress_frame_monitor: passive framing checker for a segmented stream
// bus without backpressure. It holds the open-packet state, the good
// packet counter, the sticky fault flags and the fault pulse.
// Assumes rate_sel changes only while rst_n is low.
module egress_frame_monitor
    import egr_mon_pkg::*;
#(
    parameter int NSEG  = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate_sel,
    input  logic             port_valid,
    input  logic [NSEG-1:0]  seg_en,
    input  logic [NSEG-1:0]  seg_sop,
    input  logic [NSEG-1:0]  seg_eop,
    output logic [CNT_W-1:0] good_pkts,
    output logic [ERR_W-1:0] err_flags,
    output logic             err_pulse
);

    localparam int CW = $clog2(NSEG + 1);

    logic [NSEG-1:0]  active_mask;
    logic [CW-1:0]    sop_max;
    logic [CW-1:0]    eop_max;
    logic [NSEG-1:0]  qual;
    logic             in_pkt_q;
    logic             in_pkt_nx;
    logic [CW-1:0]    good_cnt;
    logic             dup_sop;
    logic             orphan_eop;
    logic             no_sop;
    logic             sop_over;
    logic             eop_over;
    logic             cfg_err;
    logic [ERR_W-1:0] err_now;

    seg_rate_decode #(.NSEG(NSEG)) u_rate (
        .rate_sel    (rate_sel),
        .active_mask (active_mask),
        .sop_max     (sop_max),
        .eop_max     (eop_max)
    );

    // Segments that take part in this beat.
    assign qual    = {NSEG{port_valid}} & seg_en & active_mask;
    // Enable raised on a segment the rate does not use.
    assign cfg_err = port_valid & |(seg_en & ~active_mask);

    seg_frame_walk #(.NSEG(NSEG)) u_walk (
        .in_pkt_i   (in_pkt_q),
        .qual       (qual),
        .seg_sop    (seg_sop),
        .seg_eop    (seg_eop),
        .in_pkt_o   (in_pkt_nx),
        .good_cnt   (good_cnt),
        .dup_sop    (dup_sop),
        .orphan_eop (orphan_eop),
        .no_sop     (no_sop)
    );

    seg_limit_check #(.NSEG(NSEG)) u_lim (
        .qual     (qual),
        .seg_sop  (seg_sop),
        .seg_eop  (seg_eop),
        .sop_max  (sop_max),
        .eop_max  (eop_max),
        .sop_over (sop_over),
        .eop_over (eop_over)
    );

    // Gather this beat's faults into flag bit order.
    always_comb begin
        err_now                 = '0;
        err_now[ERR_DUP_SOP]    = dup_sop;
        err_now[ERR_ORPHAN_EOP] = orphan_eop;
        err_now[ERR_NO_SOP]     = no_sop;
        err_now[ERR_SOP_LIM]    = sop_over;
        err_now[ERR_EOP_LIM]    = eop_over;
        err_now[ERR_CFG]        = cfg_err;
    end

    // State, counter, sticky flags and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q  <= 1'b0;
            good_pkts <= '0;
            err_flags <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= |err_now;
            err_flags <= err_flags | err_now;
            if (port_valid) begin
                in_pkt_q  <= in_pkt_nx;
                good_pkts <= good_pkts + CNT_W'(good_cnt);
            end
        end
    end

    assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !port_valid |=> $stable(good_pkts));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !port_valid |=> !err_pulse);

    assert_cfg_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && ((seg_en & ~active_mask) != '0)) |=> (err_flags[ERR_CFG] && err_pulse));

    assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_pulse_has_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_flags != '0));

endmodule

// File: tb/sim_egress_frame_monitor.sv
`timescale 1ns/100ps
module sim_egress_frame_monitor;

    localparam int NSEG  = 8;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       rate_sel = 2'd0;
    logic             port_valid = 1'b0;
    logic [NSEG-1:0]  seg_en = '0;
    logic [NSEG-1:0]  seg_sop = '0;
    logic [NSEG-1:0]  seg_eop = '0;
    logic [CNT_W-1:0] good_pkts;
    logic [5:0]       err_flags;
    logic             err_pulse;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    // Reference state, built from the requirements.
    bit               m_in;
    logic [CNT_W-1:0] e_good;
    logic [5:0]       e_flags;
    bit               e_pulse;

    always #2.5 clk = ~clk;

    egress_frame_monitor #(.NSEG(NSEG), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .port_valid(port_valid),
        .seg_en(seg_en), .seg_sop(seg_sop), .seg_eop(seg_eop),
        .good_pkts(good_pkts), .err_flags(err_flags), .err_pulse(err_pulse)
    );

    function automatic int act_segs(input logic [1:0] r);
        return (r == 2'd1) ? 4 : (r == 2'd2) ? 8 : 2;
    endfunction

    function automatic int sop_lim(input logic [1:0] r);
        return (r == 2'd2) ? 2 : 1;
    endfunction

    function automatic int eop_lim(input logic [1:0] r);
        return (r == 2'd2) ? 3 : (r == 2'd1) ? 2 : 1;
    endfunction

    // Advance the reference model by one beat.
    task automatic model_beat(input bit v, input logic [7:0] en,
                              input logic [7:0] sp, input logic [7:0] ep);
        logic [5:0] e = '0;
        int n = act_segs(rate_sel);
        int ns = 0;
        int ne = 0;
        int g = 0;
        bit st = m_in;
        if (v) begin
            for (int i = 0; i < NSEG; i++) begin
                if (en[i] && i >= n) e[5] = 1'b1;
                if (en[i] && i < n) begin
                    if (sp[i]) ns++;
                    if (ep[i]) ne++;
                    if (sp[i] && st) e[0] = 1'b1;
                    if (sp[i]) begin
                        st = 1'b1;
                        if (ep[i]) begin g++; st = 1'b0; end
                    end else if (ep[i]) begin
                        if (st) begin g++; st = 1'b0; end
                        else e[1] = 1'b1;
                    end else if (!st) begin
                        e[2] = 1'b1;
                    end
                end
            end
            if (ns > sop_lim(rate_sel)) e[3] = 1'b1;
            if (ne > eop_lim(rate_sel)) e[4] = 1'b1;
            m_in   = st;
            e_good = e_good + CNT_W'(g);
        end
        e_flags = e_flags | e;
        e_pulse = (e != 6'd0);
    endtask

    task automatic check_out(input string tag);
        checks++;
        if (good_pkts !== e_good || err_flags !== e_flags || err_pulse !== e_pulse) begin
            failures++;
            $display("FAIL %s: got good=%0d flags=%b pulse=%b expected good=%0d flags=%b pulse=%b",
                     tag, good_pkts, err_flags, err_pulse, e_good, e_flags, e_pulse);
        end
    endtask

    task automatic check_bit(input string tag, input int idx, input bit exp);
        checks++;
        if (err_flags[idx] !== exp) begin
            failures++;
            $display("FAIL %s: flag bit %0d got %b expected %b", tag, idx, err_flags[idx], exp);
        end
    endtask

    // Apply one beat at a falling edge, pass the rising edge, check at the next falling edge.
    task automatic beat(input bit v, input logic [7:0] en, input logic [7:0] sp,
                        input logic [7:0] ep, input string tag);
        port_valid = v;
        seg_en = en;
        seg_sop = sp;
        seg_eop = ep;
        model_beat(v, en, sp, ep);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic do_reset(input logic [1:0] r, input string tag);
        rst_n = 1'b0;
        rate_sel = r;
        port_valid = 1'b0;
        seg_en = '0;
        seg_sop = '0;
        seg_eop = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_in = 1'b0;
        e_good = '0;
        e_flags = '0;
        e_pulse = 1'b0;
        check_out(tag);
    endtask

    // Watchdog: count an expired run as a failure.
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_in = 1'b0;
        e_good = '0;
        e_flags = '0;
        e_pulse = 1'b0;
        @(negedge clk);

        // R13: reset state.
        do_reset(2'd2, "R13 reset state");

        // R4: lower half idle, then a leading idle segment before the end.
        beat(1, 8'hF0, 8'h10, 8'h00, "R4 lower half idle with start");
        beat(1, 8'hE0, 8'h00, 8'h80, "R4 leading idle then end R9");
        // R3, R10, R11: open a packet, then 2 starts and 3 ends in one beat without a fault.
        beat(1, 8'h01, 8'h01, 8'h00, "R3 open packet");
        beat(1, 8'hFF, 8'h0A, 8'h85, "R3 carry-in, at limits R10 R11");
        check_bit("R10 at limit no fault", 3, 1'b0);
        check_bit("R11 at limit no fault", 4, 1'b0);
        // R8 and R10: three one-segment packets, one start over the limit.
        beat(1, 8'h07, 8'h07, 8'h07, "R8 R10 three single packets");
        check_bit("R10 start limit exceeded", 3, 1'b1);

        // R1: an invalid beat has no effect.
        beat(0, 8'hFF, 8'hFF, 8'hFF, "R1 invalid beat ignored");
        beat(0, 8'hFF, 8'hFF, 8'hFF, "R12 pulse lasts one cycle");

        // R5: duplicate start.
        do_reset(2'd2, "R13 reset clears");
        beat(1, 8'h03, 8'h03, 8'h00, "R5 duplicate start");
        check_bit("R5 flag", 0, 1'b1);
        beat(1, 8'h01, 8'h00, 8'h01, "R5 new packet closes R9");

        // R6: orphan end.
        do_reset(2'd2, "R13 reset");
        beat(1, 8'h02, 8'h00, 8'h02, "R6 orphan end");
        check_bit("R6 flag", 1, 1'b1);
        check_bit("R7 not raised by end", 2, 1'b0);

        // R7: data outside a packet.
        do_reset(2'd1, "R13 reset");
        beat(1, 8'h01, 8'h00, 8'h00, "R7 data outside packet");
        check_bit("R7 flag", 2, 1'b1);

        // R11: end limit at 2 segments and at 4 segments.
        do_reset(2'd0, "R13 reset");
        beat(1, 8'h01, 8'h01, 8'h00, "R11 open packet");
        beat(1, 8'h03, 8'h02, 8'h03, "R11 two ends at 2 segments");
        check_bit("R11 end limit exceeded", 4, 1'b1);
        do_reset(2'd1, "R13 reset");
        beat(1, 8'h01, 8'h01, 8'h00, "R11 open packet at 4 segments");
        beat(1, 8'h03, 8'h02, 8'h03, "R11 two ends allowed at 4 segments");
        check_bit("R11 no fault at 4 segments", 4, 1'b0);

        // R2: enable outside the active range.
        do_reset(2'd0, "R13 reset");
        beat(1, 8'h04, 8'h00, 8'h00, "R2 out of range enable");
        check_bit("R2 cfg flag", 5, 1'b1);
        check_bit("R2 segment kept out of framing", 2, 1'b0);
        do_reset(2'd3, "R13 reset");
        beat(1, 8'h04, 8'h04, 8'h04, "R2 reserved code acts as 2 segments");
        check_bit("R2 reserved cfg flag", 5, 1'b1);

        // Seeded random beats at each rate.
        for (int r = 0; r < 3; r++) begin
            do_reset(2'(r), "R13 reset before random");
            for (int c = 0; c < 1500; c++) begin
                logic [7:0] en = '0;
                logic [7:0] sp = '0;
                logic [7:0] ep = '0;
                bit v = ($urandom % 6) != 0;
                int n = act_segs(2'(r));
                for (int i = 0; i < NSEG; i++) begin
                    if (i < n) en[i] = ($urandom % 3) != 0;
                    else en[i] = ($urandom % 40) == 0;
                    sp[i] = ($urandom % 5) == 0;
                    ep[i] = ($urandom % 4) == 0;
                end
                beat(v, en, sp, ep, "R3 R9 R12 random traffic");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule